// File: doc/BRIEF.md
# Output Range Clamp and Depth Expander

This block is a two-stage pixel stage for a display output path. Each of three 12-bit colour channels is first widened from 8-bit or 10-bit significance to a full 12-bit value, and then optionally limited to the video (limited) range for a chosen output depth. Narrow input values arrive left-aligned in the 12-bit word. The expander fills the vacated low bits with copies of the value's top bits, so full scale stays full scale. A three-bit format code selects both the clamp bounds and the depth at which they are enforced.

All configuration inputs are captured together with the pixel they arrive with. A change of settings between two back-to-back pixels therefore affects only the later pixel. The pixel and its valid flag leave the block exactly two clock cycles after entry, one cycle per stage. Channel 0 and channel 2 carry chroma bounds by default, and channel 1 carries luma/RGB bounds; this mapping is a build-time parameter.

Top module: `pxr_clamp_expand`

## Requirements
- R1: While rst is high at a clock edge, out_valid and every bit of out_pix are 0 after that edge.
- R2: out_valid equals in_valid from two clock cycles earlier, and out_pix carries the result for that same input.
- R3: With exp_en low, each channel passes with bits [11:2] unchanged and bits [1:0] forced to 0.
- R4: With exp_en high and exp_mode 1 (8-bit source), each channel becomes {in[11:4], in[11:8]}.
- R5: With exp_en high and exp_mode 0 (10-bit source), each channel becomes {in[11:2], in[11:10]}.
- R6: With clamp_en low, or with clamp_fmt equal to 0 or to 4 through 7, the expander result passes through the clamp stage unchanged.
- R7: With clamp_en high and clamp_fmt 1 (8-bit), a luma channel above 0xEBF becomes 0xEB0, and a chroma channel above 0xF0F becomes 0xF00. Values from the low bound up to those limits pass.
- R8: With clamp_fmt 2 (10-bit), a luma channel above 0xEB3 becomes 0xEB0, and a chroma channel above 0xF03 becomes 0xF00.
- R9: With clamp_fmt 3 (12-bit), a luma channel above 0xEB0 becomes 0xEB0, and a chroma channel above 0xF00 becomes 0xF00.
- R10: In formats 1 to 3, a channel below 0x100 becomes 0x100.
- R11: Channels 0 and 2 (bits [11:0] and [35:24]) use the chroma upper bound. Channel 1 (bits [23:12]) uses the luma upper bound.
- R12: Expansion is applied before clamping.
- R13: exp_en, exp_mode, clamp_en and clamp_fmt are sampled with the pixel they accompany, so each pixel is processed with its own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| in_pix | input | 36 | Three 12-bit channels: [11:0] ch0, [23:12] ch1, [35:24] ch2 |
| exp_en | input | 1 | Depth expansion enable |
| exp_mode | input | 1 | 0: 10-bit source, 1: 8-bit source |
| clamp_en | input | 1 | Limited-range clamp enable |
| clamp_fmt | input | 3 | 0: none (6-bit), 1: 8-bit, 2: 10-bit, 3: 12-bit, 4 to 7: pass |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 36 | Processed pixel, same channel layout as in_pix |

## Verification
The bench uses values sitting just inside and just past the upper bound at each depth. A design that ignored the depth and clamped at the bare 12-bit value would cut 0xEBC at 8-bit depth, and one that enforced only 8-bit slack would let 0xEB4 through at 12 bits. Mixed luma and chroma vectors expose a swapped channel mapping. A full-scale 8-bit input that is then clamped shows whether the stages run in the wrong order, because clamping first would give 0xF0F instead of 0xF00. Back-to-back pixels with different settings catch configuration that is read at output time rather than captured with the pixel. The reserved format codes are checked as pass-through, and a single valid pulse must emerge exactly two cycles later.

// File: rtl/pxr_pkg.sv
package pxr_pkg;

    localparam int unsigned PIX_W   = 12;
    localparam int unsigned NUM_CH  = 3;
    localparam int unsigned PATH_W  = PIX_W - 2;   // width kept when expansion is off
    localparam int unsigned PLACE   = PIX_W - 8;   // shift that puts 8-bit codes into the word

    typedef logic [PIX_W-1:0]     comp_t;
    typedef comp_t [NUM_CH-1:0]   pix_t;

    typedef enum logic {
        EXP_FROM10 = 1'b0,
        EXP_FROM8  = 1'b1
    } exp_mode_e;

    typedef enum logic [2:0] {
        CLF_NONE6 = 3'd0,
        CLF_LIM8  = 3'd1,
        CLF_LIM10 = 3'd2,
        CLF_LIM12 = 3'd3,
        CLF_RSV4  = 3'd4,
        CLF_RSV5  = 3'd5,
        CLF_RSV6  = 3'd6,
        CLF_PROG  = 3'd7
    } clamp_fmt_e;

    typedef struct packed {
        logic       en;
        clamp_fmt_e fmt;
    } clamp_cfg_t;

    localparam int unsigned LO8   = 16;
    localparam int unsigned HI8_Y = 235;
    localparam int unsigned HI8_C = 240;

    localparam comp_t LO_W    = comp_t'(LO8 << PLACE);
    localparam comp_t HI_Y_W  = comp_t'(HI8_Y << PLACE);
    localparam comp_t HI_C_W  = comp_t'(HI8_C << PLACE);
    localparam comp_t HI_CEIL = comp_t'((HI8_C << PLACE) + (1 << PLACE) - 1);

    // Widen a left-aligned narrow value, refilling low bits from the top.
    function automatic comp_t widen(comp_t v, exp_mode_e m);
        comp_t       r;
        int unsigned keep;
        r    = v;
        keep = (m == EXP_FROM8) ? 8 : 10;
        for (int i = 0; i < PIX_W; i++) begin
            if (i < PIX_W - keep) r[i] = v[keep + i];
        end
        return r;
    endfunction

    // Path without expansion carries only PATH_W significant bits.
    function automatic comp_t trim(comp_t v);
        comp_t r;
        r = v;
        for (int i = 0; i < PIX_W - PATH_W; i++) r[i] = 1'b0;
        return r;
    endfunction

    function automatic comp_t limit(comp_t v, clamp_cfg_t c, logic chroma);
        comp_t hi;
        comp_t slack;
        hi = chroma ? HI_C_W : HI_Y_W;
        if (!c.en) return v;
        case (c.fmt)
            CLF_LIM8:  slack = comp_t'((1 << (PIX_W - 8)) - 1);
            CLF_LIM10: slack = comp_t'((1 << (PIX_W - 10)) - 1);
            CLF_LIM12: slack = comp_t'((1 << (PIX_W - 12)) - 1);
            default:   return v;
        endcase
        if (v < LO_W) return LO_W;
        if (v > (hi | slack)) return hi;
        return v;
    endfunction

endpackage

// File: rtl/pxr_expand.sv
module pxr_expand
    import pxr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  pix_t       in_pix,
    input  logic       exp_en,
    input  logic       exp_mode,
    input  clamp_cfg_t in_cfg,
    output logic       s_valid,
    output pix_t       s_pix,
    output clamp_cfg_t s_cfg
);

    pix_t nxt;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign nxt[g] = exp_en ? widen(in_pix[g], exp_mode_e'(exp_mode)) : trim(in_pix[g]);

        assert_from8_fullscale_R4: assert property (@(posedge clk) disable iff (rst)
            (in_valid && exp_en && exp_mode && in_pix[g][PIX_W-1 -: 8] == 8'hFF)
            |=> (s_pix[g] == {PIX_W{1'b1}}));

        assert_from10_fullscale_R5: assert property (@(posedge clk) disable iff (rst)
            (in_valid && exp_en && !exp_mode && in_pix[g][PIX_W-1 -: 10] == 10'h3FF)
            |=> (s_pix[g] == {PIX_W{1'b1}}));

        assert_noexp_lowzero_R3: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !exp_en) |=> (s_pix[g][1:0] == 2'b00));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_valid <= 1'b0;
            s_pix   <= '0;
            s_cfg   <= '0;
        end else begin
            s_valid <= in_valid;
            s_pix   <= nxt;
            s_cfg   <= in_cfg;
        end
    end

    assert_valid_stage1_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s_valid);

endmodule

// File: rtl/pxr_clamp.sv
module pxr_clamp
    import pxr_pkg::*;
#(
    parameter logic [NUM_CH-1:0] CHROMA_MASK = 3'b101
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       s_valid,
    input  pix_t       s_pix,
    input  clamp_cfg_t s_cfg,
    output logic       out_valid,
    output pix_t       out_pix
);

    pix_t lim;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign lim[g] = limit(s_pix[g], s_cfg, CHROMA_MASK[g]);

        assert_in_bounds_R7: assert property (@(posedge clk) disable iff (rst)
            (s_valid && s_cfg.en && s_cfg.fmt inside {CLF_LIM8, CLF_LIM10, CLF_LIM12})
            |=> (out_pix[g] >= LO_W && out_pix[g] <= HI_CEIL));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= s_valid;
            out_pix   <= lim;
        end
    end

    assert_valid_high_R2: assert property (@(posedge clk) disable iff (rst)
        s_valid |=> out_valid);

    assert_valid_low_R2: assert property (@(posedge clk) disable iff (rst)
        !s_valid |=> !out_valid);

    assert_pass_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        (s_valid && !s_cfg.en) |=> (out_pix == $past(s_pix)));

endmodule

// File: rtl/pxr_clamp_expand.sv
module pxr_clamp_expand
    import pxr_pkg::*;
#(
    parameter logic [NUM_CH-1:0] CHROMA_MASK = 3'b101
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [NUM_CH*PIX_W-1:0] in_pix,
    input  logic                    exp_en,
    input  logic                    exp_mode,
    input  logic                    clamp_en,
    input  logic [2:0]              clamp_fmt,
    output logic                    out_valid,
    output logic [NUM_CH*PIX_W-1:0] out_pix
);

    clamp_cfg_t in_cfg;
    logic       s_valid;
    pix_t       s_pix;
    clamp_cfg_t s_cfg;
    pix_t       o_pix;

    assign in_cfg.en  = clamp_en;
    assign in_cfg.fmt = clamp_fmt_e'(clamp_fmt);

    pxr_expand u_expand (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_pix   (pix_t'(in_pix)),
        .exp_en   (exp_en),
        .exp_mode (exp_mode),
        .in_cfg   (in_cfg),
        .s_valid  (s_valid),
        .s_pix    (s_pix),
        .s_cfg    (s_cfg)
    );

    pxr_clamp #(.CHROMA_MASK(CHROMA_MASK)) u_clamp (
        .clk       (clk),
        .rst       (rst),
        .s_valid   (s_valid),
        .s_pix     (s_pix),
        .s_cfg     (s_cfg),
        .out_valid (out_valid),
        .out_pix   (o_pix)
    );

    assign out_pix = o_pix;

endmodule

// File: tb/sim_pxr_clamp_expand.sv
module sim_pxr_clamp_expand;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [35:0] in_pix;
    logic        exp_en, exp_mode, clamp_en;
    logic [2:0]  clamp_fmt;
    logic        out_valid;
    logic [35:0] out_pix;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pxr_clamp_expand u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix),
        .exp_en(exp_en), .exp_mode(exp_mode), .clamp_en(clamp_en),
        .clamp_fmt(clamp_fmt), .out_valid(out_valid), .out_pix(out_pix)
    );

    // {pix, exp_en, exp_mode, clamp_en, clamp_fmt, expected}
    localparam int NV = 13;
    localparam logic [77:0] VEC [NV] = '{
        {36'h123456789, 1'b0, 1'b0, 1'b0, 3'd0, 36'h120454788},
        {36'hFF000080F, 1'b1, 1'b1, 1'b0, 3'd0, 36'hFFF000808},
        {36'hFFC003A55, 1'b1, 1'b0, 1'b0, 3'd0, 36'hFFF000A56},
        {36'hF0CEBC0FC, 1'b0, 1'b0, 1'b1, 3'd1, 36'hF0CEBC100},
        {36'hF0CEBC0FC, 1'b0, 1'b0, 1'b1, 3'd2, 36'hF00EB0100},
        {36'hF00EB4800, 1'b0, 1'b0, 1'b1, 3'd3, 36'hF00EB0800},
        {36'hEF0EF0EF0, 1'b0, 1'b0, 1'b1, 3'd3, 36'hEF0EB0EF0},
        {36'hFFC000004, 1'b0, 1'b0, 1'b1, 3'd0, 36'hFFC000004},
        {36'hFFC000004, 1'b0, 1'b0, 1'b1, 3'd7, 36'hFFC000004},
        {36'hFFC000004, 1'b0, 1'b0, 1'b1, 3'd5, 36'hFFC000004},
        {36'hFFC000004, 1'b0, 1'b0, 1'b0, 3'd3, 36'hFFC000004},
        {36'h0F80000FC, 1'b0, 1'b0, 1'b1, 3'd2, 36'h100100100},
        {36'hFF0FF0010, 1'b1, 1'b1, 1'b1, 3'd1, 36'hF00EB0100}
    };
    localparam string TAG [NV] = '{
        "R3", "R4", "R5", "R7", "R8", "R9", "R11",
        "R6", "R6", "R6", "R6", "R10", "R12"
    };

    task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(logic v, logic [35:0] p, logic ee, logic em, logic ce, logic [2:0] cf);
        in_valid  = v;
        in_pix    = p;
        exp_en    = ee;
        exp_mode  = em;
        clamp_en  = ce;
        clamp_fmt = cf;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(10 * 100000);
        errors++;
        $display("FAIL watchdog actual hung expected finished");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        drive(1'b1, 36'hFFFFFFFFF, 1'b1, 1'b1, 1'b1, 3'd1);
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 valid", {35'd0, out_valid}, 36'd0);
        chk("R1 pix", out_pix, 36'd0);

        rst = 1'b0;
        drive(1'b0, 36'd0, 1'b0, 1'b0, 1'b0, 3'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);

        // R2: single valid pulse emerges two cycles later
        drive(1'b1, 36'h400400400, 1'b0, 1'b0, 1'b0, 3'd0);
        @(posedge clk);
        @(negedge clk);
        drive(1'b0, 36'd0, 1'b0, 1'b0, 1'b0, 3'd0);
        chk("R2 after1", {35'd0, out_valid}, 36'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R2 after2", {35'd0, out_valid}, 36'd1);
        chk("R2 data", out_pix, 36'h400400400);
        @(posedge clk);
        @(negedge clk);
        chk("R2 after3", {35'd0, out_valid}, 36'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VEC[i][77:42], VEC[i][41], VEC[i][40], VEC[i][39], VEC[i][38:36]);
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            chk(TAG[i], out_pix, VEC[i][35:0]);
            chk({TAG[i], " valid"}, {35'd0, out_valid}, 36'd1);
        end

        // R13: back-to-back pixels with different settings
        drive(1'b1, 36'hFFC000004, 1'b0, 1'b0, 1'b1, 3'd3);
        @(posedge clk);
        @(negedge clk);
        drive(1'b1, 36'hFFC000004, 1'b0, 1'b0, 1'b0, 3'd3);
        @(posedge clk);
        @(negedge clk);
        drive(1'b0, 36'd0, 1'b1, 1'b1, 1'b1, 3'd1);
        chk("R13 first", out_pix, 36'hF00100100);
        @(posedge clk);
        @(negedge clk);
        chk("R13 second", out_pix, 36'hFFC000004);

        finish_run();
    end

endmodule